// File: doc/BRIEF.md
# Byte-Strobed Word Memory Subordinate

This block is a bus subordinate on a 64-bit AHB data path that fronts a small array of 64-bit words. The address phase of each transfer is registered. The write, if there is one, then lands in the following data phase. The byte lanes a write may touch are worked out from the low address bits and the transfer size alone. Each of those lanes is then gated by its own strobe bit, so a manager can write any subset of the addressed bytes (a sparse write). Strobe bits on lanes outside the addressed range are never looked at.

Reads return the whole stored word in the data phase that follows their address phase. Every transfer completes at once with an OKAY response. No back-pressure is ever applied: the ready output stays high, so an upstream manager never stalls. A manager that has no strobe support can tie every strobe bit high and gets plain full-lane writes.

Top module: `strb_mem_sub`

## Requirements
- R1: For size code 0 (byte), the only active lane is the one numbered by address bits [2:0].
- R2: For size code 1 (halfword), the active lanes are 2*addr[2:1] and 2*addr[2:1]+1.
- R3: For size code 2 (word), the active lanes are 4*addr[2] through 4*addr[2]+3. An aligned word at offset 0 uses lanes 0 to 3 and leaves lanes 4 to 7 inactive.
- R4: For size code 3 (doubleword), all eight lanes are active.
- R5: An active lane whose strobe bit is 1 takes byte lane n of the write data, which is bits [8n+7:8n].
- R6: An active lane whose strobe bit is 0 keeps its stored byte.
- R7: A strobe bit on an inactive lane has no effect on storage, whether it is 0 or 1.
- R8: A write with all strobe bits at 1 updates every active lane of the transfer.
- R9: An address phase is accepted only when select is 1, ready-in is 1 and the transfer type is NONSEQ (2'b10) or SEQ (2'b11). The write data and strobes are sampled in the next cycle. IDLE (2'b00) and BUSY (2'b01) transfers change nothing.
- R10: Ready-out is always 1 and the response is always OKAY (0).
- R11: Read data shows the addressed stored word during the data phase of a read. A read whose address phase overlaps the data phase of a write to the same word returns the newly written bytes.
- R12: Reset clears every stored byte to zero. The word index is taken from address bits [6:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Subordinate select |
| bus_ready_in | input | 1 | Bus ready seen by all subordinates |
| bus_trans | input | 2 | Transfer type |
| bus_write | input | 1 | 1 for a write transfer |
| bus_size | input | 3 | Transfer size code (0 to 3) |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 64 | Write data, valid in the data phase |
| bus_strobe | input | 8 | Per-lane write strobe, valid in the data phase |
| bus_rdata | output | 64 | Read data |
| bus_ready_out | output | 1 | Transfer done; held at 1 |
| bus_resp | output | 1 | Response; held at OKAY (0) |

## Verification
The assertions assume a few things about the inputs. Select, ready-in and transfer type are at known values at every clock edge after reset. The size code stays within 0 to 3. Data and strobes are stable through the data phase. The stimulus drives every input only at falling edges and holds select low during reset. It uses only the four legal size codes, each at an offset aligned to that size, so every write lands on a well-defined lane range.

// File: rtl/strb_mem_pkg.sv
package strb_mem_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3
  } size_e;

  localparam logic RESP_OKAY = 1'b0;

  // An address phase counts only for NONSEQ or SEQ.
  function automatic logic trans_active(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/strb_lane_decode.sv
module strb_lane_decode #(
  parameter int LANES = 8,
  parameter int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [2:0]       size,
  output logic [LANES-1:0] mask
);
  // A lane is active when it shares the same size-aligned block as the offset.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(g);
    always_comb begin
      if (int'(size) >= OFS_W) mask[g] = 1'b1;
      else mask[g] = ((LANE_ID ^ ofs) >> size) == '0;
    end
  end
endmodule

// File: rtl/strb_addr_phase.sv
module strb_addr_phase #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 3,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              ready_in,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              dp_valid,
  output logic              dp_write,
  output logic [2:0]        dp_size,
  output logic [OFS_W-1:0]  dp_ofs,
  output logic [IDX_W-1:0]  dp_idx
);
  import strb_mem_pkg::*;

  logic take;
  assign take = sel && ready_in && trans_active(trans);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_size  <= '0;
      dp_ofs   <= '0;
      dp_idx   <= '0;
    end else if (ready_in) begin
      dp_valid <= take;
      if (take) begin
        dp_write <= write;
        dp_size  <= size;
        dp_ofs   <= addr[OFS_W-1:0];
        dp_idx   <= addr[OFS_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/strb_word_store.sv
module strb_word_store #(
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [8*LANES-1:0] wdata,
  input  logic [IDX_W-1:0]   ridx,
  output logic [8*LANES-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_col
    logic [7:0] col [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) col[i] <= '0;
      end else if (we[l]) begin
        col[widx] <= wdata[8*l +: 8];
      end
    end
    assign rdata[8*l +: 8] = col[ridx];
  end
endmodule

// File: rtl/strb_mem_sub.sv
module strb_mem_sub #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_ready_in,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W/8-1:0] bus_strobe,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready_out,
  output logic              bus_resp
);
  import strb_mem_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int IDX_W = $clog2(DEPTH);

  logic              dp_valid, dp_write;
  logic [2:0]        dp_size;
  logic [OFS_W-1:0]  dp_ofs;
  logic [IDX_W-1:0]  dp_idx;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  byte_we;

  strb_addr_phase #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) aphase_i (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .ready_in(bus_ready_in),
    .trans(bus_trans), .write(bus_write), .size(bus_size), .addr(bus_addr),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_size(dp_size),
    .dp_ofs(dp_ofs), .dp_idx(dp_idx)
  );

  strb_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) decode_i (
    .ofs(dp_ofs), .size(dp_size), .mask(lane_mask)
  );

  assign byte_we = {LANES{dp_valid && dp_write}} & lane_mask & bus_strobe;

  strb_word_store #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst_n(rst_n), .we(byte_we), .widx(dp_idx),
    .wdata(bus_wdata), .ridx(dp_idx), .rdata(bus_rdata)
  );

  assign bus_ready_out = 1'b1;
  assign bus_resp      = RESP_OKAY;
endmodule

// File: rtl/strb_mem_sub_chk.sv
module strb_mem_sub_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_ready_in,
  input logic [1:0]       bus_trans,
  input logic [LANES-1:0] bus_strobe,
  input logic             bus_ready_out,
  input logic             bus_resp,
  input logic             dp_valid,
  input logic             dp_write,
  input logic [2:0]       dp_size,
  input logic [LANES-1:0] byte_we
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(bus_ready_in) |->
      dp_valid == $past(bus_sel && bus_trans[1]));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_valid && dp_write) |-> byte_we == '0);

  p_low_strobe_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we & ~bus_strobe) == '0);

  p_byte_one_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && dp_size == 3'd0 |-> $countones(byte_we) <= 1);

  p_dword_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && dp_write && dp_size == 3'd3 |-> byte_we == bus_strobe);

  p_no_wait_okay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready_out && !bus_resp);
endmodule

bind strb_mem_sub strb_mem_sub_chk #(.LANES(DATA_W/8)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_ready_in(bus_ready_in),
  .bus_trans(bus_trans), .bus_strobe(bus_strobe),
  .bus_ready_out(bus_ready_out), .bus_resp(bus_resp),
  .dp_valid(dp_valid), .dp_write(dp_write), .dp_size(dp_size),
  .byte_we(byte_we)
);

// File: tb/strb_mem_sub_tb.sv
module strb_mem_sub_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_ready_in = 1'b1, bus_write = 1'b0;
  logic [1:0]  bus_trans = 2'b00;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [7:0]  bus_strobe = '0;
  logic [63:0] bus_rdata;
  logic        bus_ready_out, bus_resp;

  int checks = 0;
  int errors = 0;
  logic [7:0] refm [DEPTH][8];

  always #4 clk = ~clk;

  strb_mem_sub dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_ready_in(bus_ready_in),
    .bus_trans(bus_trans), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strobe(bus_strobe),
    .bus_rdata(bus_rdata), .bus_ready_out(bus_ready_out), .bus_resp(bus_resp)
  );

  function automatic logic [63:0] ref_word(int w);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[8*l +: 8] = refm[w][l];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference lane range: block of 2**sz lanes containing ofs.
  task automatic ref_write(int w, int ofs, int sz, logic [63:0] d, logic [7:0] st);
    int cnt = 1 << sz;
    int base = (ofs / cnt) * cnt;
    for (int l = base; l < base + cnt; l++)
      if (st[l]) refm[w][l] = d[8*l +: 8];
  endtask

  task automatic wr(int w, int ofs, int sz, logic [63:0] d, logic [7:0] st);
    @(negedge clk);
    bus_sel = 1; bus_trans = 2'b10; bus_write = 1; bus_size = 3'(sz);
    bus_addr = 32'(w * 8 + ofs);
    @(negedge clk);
    bus_sel = 0; bus_trans = 2'b00; bus_wdata = d; bus_strobe = st;
    @(posedge clk);
    ref_write(w, ofs, sz, d, st);
  endtask

  task automatic rd_check(int w, string tag);
    @(negedge clk);
    bus_sel = 1; bus_trans = 2'b11; bus_write = 0; bus_size = 3'd3;
    bus_addr = 32'(w * 8);
    @(negedge clk);
    bus_sel = 0; bus_trans = 2'b00;
    chk(tag, bus_rdata, ref_word(w));
    chk("R10 ready/resp", {63'd0, bus_ready_out && !bus_resp}, 64'd1);
  endtask

  function automatic string size_tag(int sz);
    case (sz)
      0: return "R1 byte";
      1: return "R2 half";
      2: return "R3 word";
      default: return "R4 dword";
    endcase
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog R10 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int iter = 0;
    for (int w = 0; w < DEPTH; w++)
      for (int l = 0; l < 8; l++) refm[w][l] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: cleared after reset
    for (int w = 0; w < DEPTH; w++) rd_check(w, "R12 reset clear");

    // Sweep every size, every aligned offset, four strobe patterns.
    for (int sz = 0; sz < 4; sz++) begin
      for (int ofs = 0; ofs < 8; ofs += (1 << sz)) begin
        for (int p = 0; p < 4; p++) begin
          int cnt = 1 << sz;
          int base = (ofs / cnt) * cnt;
          logic [7:0] act = 8'(((1 << cnt) - 1) << base);
          logic [7:0] st;
          logic [63:0] d = {8{8'(iter * 37 + 11)}} ^ (64'h0F1E2D3C4B5A6978 << (iter % 8));
          string tag;
          case (p)
            0: begin st = 8'hFF; tag = "R8 R7 all-ones"; end
            1: begin st = 8'h00; tag = "R6 all-zero"; end
            2: begin st = 8'h5A ^ 8'(iter); tag = "R5 R6 sparse"; end
            default: begin st = ~act; tag = "R7 inactive-only"; end
          endcase
          wr(iter % DEPTH, ofs, sz, d, st);
          rd_check(iter % DEPTH, {size_tag(sz), " ", tag});
          iter++;
        end
      end
    end

    // R3: aligned word at offset 0 leaves lanes 4..7 untouched
    wr(5, 0, 3, 64'h1111_1111_1111_1111, 8'hFF);
    wr(5, 0, 2, 64'hAAAA_AAAA_BBBB_BBBB, 8'hFF);
    rd_check(5, "R3 word lanes 0-3 only");
    chk("R3 upper kept", ref_word(5), 64'h1111_1111_BBBB_BBBB);

    // R9: ignored transfers (IDLE, BUSY, sel low, ready_in low)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_sel = (k != 2); bus_write = 1; bus_size = 3'd3; bus_addr = 32'(7 * 8);
      bus_trans = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b10;
      bus_ready_in = (k != 3);
      @(negedge clk);
      bus_sel = 0; bus_trans = 2'b00; bus_ready_in = 1;
      bus_wdata = 64'hDEAD_BEEF_DEAD_BEEF; bus_strobe = 8'hFF;
      @(negedge clk);
      rd_check(7, "R9 ignored transfer");
    end

    // R11: read address phase overlaps the write data phase
    @(negedge clk);
    bus_sel = 1; bus_trans = 2'b10; bus_write = 1; bus_size = 3'd1;
    bus_addr = 32'(9 * 8 + 6);
    @(negedge clk);
    bus_wdata = 64'hC3C2_0000_0000_0000; bus_strobe = 8'hFF;
    bus_trans = 2'b10; bus_write = 0; bus_size = 3'd3; bus_addr = 32'(9 * 8);
    @(posedge clk);
    ref_write(9, 6, 1, 64'hC3C2_0000_0000_0000, 8'hFF);
    @(negedge clk);
    bus_sel = 0; bus_trans = 2'b00;
    chk("R11 read after write", bus_rdata, ref_word(9));
    chk("R11 new bytes", {48'd0, bus_rdata[63:48]}, 64'hC3C2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule